// File: doc/BRIEF.md
# ADC Conversion Sequencer with Sleep Handling

This block is the digital side of a 10-bit successive-approximation converter inside a microcontroller. Software programs it through a small byte-wide register port. A control byte holds the power enable, a start/busy bit, a two-bit conversion clock source, a result layout bit, an interrupt enable and a completion flag. After a start, the block samples, then resolves one result bit per conversion clock, from the most significant bit down. It drives a trial code to the analog comparator and reads back a single decision bit. The finished value goes into a high/low byte pair, packed toward the top or toward the bottom of the 16 bits.

The block also follows the processor's sleep request. With the free-running RC tick as the clock source, a conversion carries on through sleep and can wake the processor when it ends. With any divided system clock as the source, sleep cancels the conversion. In both cases the enable bit keeps its value. A device reset clears the control state but never touches the result bytes. While the converter is disabled, those bytes are plain scratch registers that software can read and write.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control byte (address 0) reads 0x00, `pwr_on` is 0 and `wake` is 0. Control byte layout: bit0 enable, bit1 start/busy, bits3:2 clock source, bit4 layout, bit5 interrupt enable, bit6 done flag, bit7 reads 0. The high result byte is at address 1, the low result byte at address 2, and address 3 reads 0.
- R2: With layout bit = 1, a finished result V is stored as high byte = {6'b0, V[9:8]} and low byte = V[7:0].
- R3: With layout bit = 0, a finished result V is stored as high byte = V[9:2] and low byte = {V[1:0], 6'b0}.
- R4: The comparator input is 1 when the analog input is at or above `dac_code`. The result equals the input value. A conversion takes 11 conversion clocks: one to sample, then one per bit. Clock sources 0, 1 and 2 tick every DIV_A, DIV_B and DIV_C system clocks. At the end the busy bit clears and the done flag sets.
- R5: A start written while the enable bit is 0 is ignored. While enable is 0, the result bytes accept writes and read back. While enable is 1, software writes to them are ignored.
- R6: With clock source 3, the conversion begins one system clock after the start write. An `rc_tick` in that cycle does not count.
- R7: Under sleep with source 3, a running conversion completes. If the interrupt enable is set, `wake` pulses for one cycle at the end. If it is clear, `wake` stays 0. Either way, `pwr_on` drops once the conversion is idle and the enable bit stays 1.
- R8: Under sleep with source 0 to 2, a running conversion is aborted in the next cycle. Busy clears, the result bytes keep their contents, `pwr_on` is 0 and the enable bit stays 1.
- R9: Reset aborts a conversion and clears the control byte, but leaves both result bytes unchanged.
- R10: Writing the control byte with enable = 0 during a conversion aborts it, without changing the result bytes.
- R11: Writing bit6 = 0 clears the done flag. Writing bit6 = 1 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low device reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sleep_req | input | 1 | Processor sleep level |
| rc_tick | input | 1 | One-cycle pulse from the RC conversion clock |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dac_code | output | 10 | Trial code to the comparator |
| wake | output | 1 | Wake-up pulse at the end of a conversion under sleep |
| pwr_on | output | 1 | Analog converter power enable |

## Verification
Several properties hold on every cycle: busy implies enabled, sleep on a divided clock source leaves the converter idle one cycle later, and `wake` is a single-cycle pulse tied to the done flag and the interrupt enable. Also checked each cycle are that the converter is unpowered whenever it is idle under sleep, and that the zero-filled bits of each layout are zero just after a completion. Other behaviour only the bench scenarios can show. This covers the correct value from the bit loop and the exact count of conversion clocks. It also covers the ignored RC tick in the start delay, and the survival of the result bytes across an abort or a reset.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       sleep_req,
  input  logic       rc_tick,
  input  logic       cmp_in,
  output logic [9:0] dac_code,
  output logic       wake,
  output logic       pwr_on
);
  localparam int CW = $clog2(DIV_C) + 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SAMP, S_CONV} st_t;

  st_t          st_q;
  logic         en_q, fmt_q, ie_q, done_q, wake_q;
  logic [1:0]   csel_q;
  logic [9:0]   sar_q;
  logic [3:0]   bit_q;
  logic [CW-1:0] cnt_q, lim;
  logic [7:0]   res_hi_q, res_lo_q;

  logic wr_ctrl, busy, rc_sel, active, ctick, abort, start, fin;
  logic [9:0] fin_val;

  assign wr_ctrl = wr_en && wr_addr == 2'd0;
  assign busy    = st_q != S_IDLE;
  assign rc_sel  = csel_q == 2'b11;
  assign active  = st_q == S_SAMP || st_q == S_CONV;

  always_comb begin
    case (csel_q)
      2'b00:   lim = CW'(DIV_A - 1);
      2'b01:   lim = CW'(DIV_B - 1);
      default: lim = CW'(DIV_C - 1);
    endcase
  end

  assign ctick   = rc_sel ? rc_tick : (cnt_q == lim);
  assign abort   = busy && ((sleep_req && !rc_sel) || (wr_ctrl && !wr_data[0]));
  assign start   = wr_ctrl && wr_data[0] && wr_data[1] && en_q && !busy && !sleep_req;
  assign fin     = st_q == S_CONV && ctick && bit_q == 4'd0 && !abort;
  assign fin_val = {sar_q[9:1], cmp_in};

  assign dac_code = sar_q | ((st_q == S_CONV) ? (10'd1 << bit_q) : 10'd0);
  assign wake     = wake_q;
  assign pwr_on   = en_q && (!sleep_req || (busy && rc_sel));

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {1'b0, done_q, ie_q, fmt_q, csel_q, busy, en_q};
      2'd1:    rd_data = res_hi_q;
      2'd2:    rd_data = res_lo_q;
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!active || ctick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sar_q <= '0;
      bit_q <= '0;
    end else if (abort) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (start) st_q <= (wr_data[3:2] == 2'b11) ? S_WAIT : S_SAMP;
        S_WAIT: st_q <= S_SAMP;
        S_SAMP: if (ctick) begin
          st_q  <= S_CONV;
          bit_q <= 4'd9;
          sar_q <= '0;
        end
        S_CONV: if (ctick) begin
          sar_q[bit_q] <= cmp_in;
          if (bit_q == 4'd0) st_q <= S_IDLE;
          else bit_q <= bit_q - 4'd1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      csel_q <= 2'b00;
      fmt_q  <= 1'b0;
      ie_q   <= 1'b0;
      done_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data[0];
        csel_q <= wr_data[3:2];
        fmt_q  <= wr_data[4];
        ie_q   <= wr_data[5];
        if (!wr_data[6]) done_q <= 1'b0;
      end
      if (fin) done_q <= 1'b1;
      wake_q <= fin && sleep_req && ie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (fin) begin
      if (fmt_q) begin
        res_hi_q <= {6'b0, fin_val[9:8]};
        res_lo_q <= fin_val[7:0];
      end else begin
        res_hi_q <= fin_val[9:2];
        res_lo_q <= {fin_val[1:0], 6'b0};
      end
    end else if (wr_en && !en_q) begin
      if (wr_addr == 2'd1) res_hi_q <= wr_data;
      if (wr_addr == 2'd2) res_lo_q <= wr_data;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       wake,
  input logic       pwr_on,
  input logic       en,
  input logic       busy,
  input logic [1:0] csel,
  input logic       done,
  input logic       fmt,
  input logic       ie,
  input logic [7:0] hi,
  input logic [7:0] lo
);
  p_busy_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en);

  p_right_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(fmt)) |-> hi[7:2] == 6'b0);

  p_left_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(fmt)) |-> lo[5:0] == 6'b0);

  p_sleep_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && csel != 2'b11) |=> !busy);

  p_wake_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (done && $past(ie) && $past(sleep_req)));

  p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_idle_sleep_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !busy) |-> !pwr_on);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake(wake), .pwr_on(pwr_on),
  .en(en_q), .busy(busy), .csel(csel_q), .done(done_q), .fmt(fmt_q), .ie(ie_q),
  .hi(res_hi_q), .lo(res_lo_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int DA = 2, DB = 8, DC = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic sleep_req = 1'b0, rc_tick = 1'b0, cmp_in, wake, pwr_on;
  logic [9:0] dac_code, ain = 10'd0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign cmp_in = ain >= dac_code;

  adc_seq_ctrl #(.DIV_A(DA), .DIV_B(DB), .DIV_C(DC)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sleep_req(sleep_req), .rc_tick(rc_tick),
    .cmp_in(cmp_in), .dac_code(dac_code), .wake(wake), .pwr_on(pwr_on)
  );

  function automatic logic [7:0] exp_hi(input logic [9:0] v, input logic f);
    return f ? {6'b0, v[9:8]} : v[9:2];
  endfunction
  function automatic logic [7:0] exp_lo(input logic [9:0] v, input logic f);
    return f ? v[7:0] : {v[1:0], 6'b0};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse();
    rc_tick = 1'b1;
    @(negedge clk);
    rc_tick = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] c;
    n = 0;
    rd(2'd0, c);
    while (c[1] && n < 5000) begin
      @(negedge clk);
      n++;
      rd(2'd0, c);
    end
  endtask

  task automatic check_result(input logic [9:0] v, input logic f, input string req);
    logic [7:0] h, l;
    rd(2'd1, h);
    rd(2'd2, l);
    chk(h == exp_hi(v, f), req, h, exp_hi(v, f));
    chk(l == exp_lo(v, f), req, l, exp_lo(v, f));
  endtask

  task automatic divided_conv(input logic [9:0] v, input logic f, input logic [1:0] cs);
    int n, div;
    logic [7:0] c;
    div = (cs == 2'd0) ? DA : (cs == 2'd1) ? DB : DC;
    ain = v;
    wr(2'd0, 8'h01);
    wr(2'd0, {3'b000, f, cs, 2'b11});
    wait_idle(n);
    chk(n == 11 * div, "R4 cycle count", n, 11 * div);
    rd(2'd0, c);
    chk(c[6] == 1'b1 && c[1] == 1'b0, "R4 done set busy clear", c, 8'h40);
    check_result(v, f, f ? "R2 right layout" : "R3 left layout");
    wr(2'd0, 8'h41);
    rd(2'd0, c);
    chk(c[6] == 1'b1, "R11 write 1 keeps done", c[6], 1);
    wr(2'd0, 8'h01);
    rd(2'd0, c);
    chk(c[6] == 1'b0, "R11 done cleared", c[6], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] c, h0, l0, h, l;
    int n;
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, c);
    chk(c == 8'h00, "R1 ctrl reset", c, 8'h00);
    chk(pwr_on == 1'b0 && wake == 1'b0, "R1 outputs reset", {pwr_on, wake}, 0);
    rd(2'd3, c);
    chk(c == 8'h00, "R1 addr3 reads 0", c, 0);

    // R5 scratch registers and ignored start
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h3C);
    rd(2'd1, h); rd(2'd2, l);
    chk(h == 8'hA5 && l == 8'h3C, "R5 scratch write", {h, l}, 16'hA53C);
    wr(2'd0, 8'h02);
    rd(2'd0, c);
    chk(c[1] == 1'b0, "R5 start ignored when disabled", c, 0);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h11);
    rd(2'd1, h);
    chk(h == 8'hA5, "R5 write ignored when enabled", h, 8'hA5);
    chk(pwr_on == 1'b1, "R1 pwr_on follows enable", pwr_on, 1);

    // R2 R3 R4 directed corners
    divided_conv(10'h000, 1'b1, 2'd0);
    divided_conv(10'h3FF, 1'b0, 2'd0);
    divided_conv(10'h200, 1'b1, 2'd1);
    divided_conv(10'h001, 1'b0, 2'd1);
    divided_conv(10'h1FF, 1'b1, 2'd2);
    // random
    for (int i = 0; i < 8; i++)
      divided_conv(10'($urandom), 1'($urandom), 2'($urandom_range(0, 2)));

    // R6 RC start delay
    ain = 10'h2D7;
    wr(2'd0, 8'h1F);
    pulse();
    for (int i = 0; i < 10; i++) pulse();
    rd(2'd0, c);
    chk(c[1] == 1'b1, "R6 tick in delay cycle ignored", c[1], 1);
    pulse();
    rd(2'd0, c);
    chk(c[1] == 1'b0, "R6 done after 11 counted ticks", c[1], 0);
    check_result(10'h2D7, 1'b1, "R6 RC result");

    // R7 sleep on RC, interrupt enabled
    wr(2'd0, 8'h01);
    ain = 10'h15A;
    wr(2'd0, 8'h3F);
    @(negedge clk);
    sleep_req = 1'b1;
    #1 chk(pwr_on == 1'b1, "R7 powered while converting asleep", pwr_on, 1);
    for (int i = 0; i < 10; i++) pulse();
    chk(wake == 1'b0, "R7 no early wake", wake, 0);
    pulse();
    chk(wake == 1'b1, "R7 wake pulse", wake, 1);
    @(negedge clk);
    chk(wake == 1'b0, "R7 wake one cycle", wake, 0);
    chk(pwr_on == 1'b0, "R7 off after completion", pwr_on, 1'b0);
    rd(2'd0, c);
    chk(c[0] == 1'b1 && c[6] == 1'b1, "R7 enable kept, done set", c, 8'h41);
    check_result(10'h15A, 1'b1, "R7 sleep result");
    sleep_req = 1'b0;

    // R7 sleep on RC, interrupt disabled
    wr(2'd0, 8'h01);
    ain = 10'h0C3;
    wr(2'd0, 8'h0F);
    @(negedge clk);
    sleep_req = 1'b1;
    n = 0;
    for (int i = 0; i < 11; i++) begin
      pulse();
      if (wake) n++;
    end
    @(negedge clk);
    chk(n == 0 && wake == 1'b0, "R7 no wake without ie", n, 0);
    chk(pwr_on == 1'b0, "R7 powered down without ie", pwr_on, 0);
    rd(2'd0, c);
    chk(c[0] == 1'b1, "R7 enable kept without ie", c[0], 1);
    check_result(10'h0C3, 1'b0, "R7 no-ie result");
    sleep_req = 1'b0;

    // R8 sleep aborts divided-clock conversion
    wr(2'd0, 8'h01);
    rd(2'd1, h0); rd(2'd2, l0);
    ain = 10'h3A0;
    wr(2'd0, 8'h1B);
    repeat (20) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    rd(2'd0, c);
    chk(c[1] == 1'b0, "R8 busy cleared by sleep", c[1], 0);
    chk(c[0] == 1'b1, "R8 enable kept", c[0], 1);
    chk(pwr_on == 1'b0, "R8 powered down", pwr_on, 0);
    repeat (400) @(negedge clk);
    rd(2'd0, c);
    chk(c[6] == 1'b0, "R8 no completion after abort", c[6], 0);
    rd(2'd1, h); rd(2'd2, l);
    chk(h == h0 && l == l0, "R8 results kept", {h, l}, {h0, l0});
    sleep_req = 1'b0;
    #1 chk(pwr_on == 1'b1, "R8 powered on after wake", pwr_on, 1);

    // R10 disable aborts
    wr(2'd0, 8'h07);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h00);
    rd(2'd0, c);
    chk(c[1] == 1'b0, "R10 disable aborts", c[1], 0);
    repeat (400) @(negedge clk);
    rd(2'd1, h); rd(2'd2, l);
    chk(h == h0 && l == l0, "R10 results kept", {h, l}, {h0, l0});

    // R9 reset aborts, results kept
    wr(2'd0, 8'h01);
    ain = 10'h111;
    wr(2'd0, 8'h0B);
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, c);
    chk(c == 8'h00, "R9 ctrl cleared", c, 0);
    chk(pwr_on == 1'b0, "R9 powered off", pwr_on, 0);
    rd(2'd1, h); rd(2'd2, l);
    chk(h == h0 && l == l0, "R9 results kept", {h, l}, {h0, l0});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule